// File: doc/BRIEF.md
# Six-Channel Pulse Generator with Start Delay and Burst Count

This block produces six independent rectangular waveforms, one per output pin, each programmed through a small 32-bit register window. For every channel, software sets an on-time and an off-time in clock cycles, an optional delay that keeps the pin low after the channel is switched on, and an optional burst length. A burst length of zero lets the waveform run until the channel is switched off.

Each channel has a control word and a timing word. The control word holds the run bit, the start delay and the burst length. The timing word holds the on-time and the off-time. Timing values are sampled only when a new period begins. A period already in progress always completes with the values it started with. Clearing the run bit abandons the waveform at the next clock edge.

The register interface is a plain single-cycle write strobe with a combinational read port. There is no data stream at the block's edge, so no valid/ready handshake is involved and no back-pressure applies.

Top module: `pwm_lead_array`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every register to zero and forces every output low.
- R2: The control word of channel n sits at byte offset 4·n and the timing word at byte offset 0x20 + 4·n. Control bit 31 is the run bit, bits 30:16 the start delay and bits 15:0 the burst length. Timing bits 31:16 are the on-time and bits 15:0 the off-time. Every mapped register reads back the last value written to it.
- R3: A read at any offset that is not a mapped register, including offsets that are not word-aligned, returns zero. A write there changes no register and no output.
- R4: If the run bit is written at clock edge k, the output stays low through edge k+D and first goes high after edge k+1+D, where D is the start delay.
- R5: While a channel runs, its output is high for exactly the on-time cycles and then low for exactly the off-time cycles, period after period (normal polarity only).
- R6: A nonzero burst length B stops the waveform after B complete periods, and the output then stays low while the run bit remains set. A burst length of zero repeats the waveform without end.
- R7: If the run bit is observed clear at a clock edge, the output is low after that edge, even in the middle of a period.
- R8: A timing word written while a channel runs takes effect at the next period start. The current period completes with its old on-time and off-time.
- R9: An on-time of zero gives a constant low output. An off-time of zero gives a constant high output while the waveform runs.
- R10: The channels are independent. Programming or running one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W (6) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (6) | One waveform output per channel |

## Verification
The bench counts cycles exactly from the edge that latches the run bit. A design that is off by one in the start delay or in either phase length shifts every later edge and is caught at once. It rewrites the timing word two cycles into a running period: a design that applied the new values immediately would shorten the first high phase. It clears the run bit mid-high and expects the output low one edge later, which catches both a design that finishes the period and one that holds the output. Zero on-time, zero off-time, a single-period burst, writes to unaligned and unmapped offsets, and channels started on staggered edges are each run, so a wrong wrap, a missed stop after the burst, or an alias in the address decode shows up as a miscompare on some channel.

// File: rtl/pwm_lead_pkg.sv
package pwm_lead_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int LEAD_W = DATA_W - CNT_W - 1;

  // control word: run bit on top, start delay in the middle, burst length low
  typedef struct packed {
    logic              run;
    logic [LEAD_W-1:0] delay;
    logic [CNT_W-1:0]  burst;
  } ctrl_word_t;

  // timing word: on-time high half, off-time low half
  typedef struct packed {
    logic [CNT_W-1:0] on_t;
    logic [CNT_W-1:0] off_t;
  } time_word_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DELAY,
    PH_HIGH,
    PH_LOW,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/pwm_lead_regs.sv
module pwm_lead_regs
  import pwm_lead_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int ADDR_W   = 6,
  parameter int TIM_BASE = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output ctrl_word_t [NUM_CH-1:0]        ctrl_q,
  output time_word_t [NUM_CH-1:0]        time_q
);
  localparam int BYTES_PER_WORD = DATA_W / 8;

  logic [NUM_CH-1:0] hit_ctrl;
  logic [NUM_CH-1:0] hit_time;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_reg
    localparam logic [ADDR_W-1:0] CTRL_AD = ADDR_W'(BYTES_PER_WORD * n);
    localparam logic [ADDR_W-1:0] TIME_AD = ADDR_W'(TIM_BASE + BYTES_PER_WORD * n);

    ctrl_word_t c_r;
    time_word_t t_r;

    assign hit_ctrl[n] = (addr == CTRL_AD);
    assign hit_time[n] = (addr == TIME_AD);

    always_ff @(posedge clk) begin
      if (rst) begin
        c_r <= '0;
        t_r <= '0;
      end else if (wr) begin
        if (hit_ctrl[n]) c_r <= ctrl_word_t'(wdata);
        if (hit_time[n]) t_r <= time_word_t'(wdata);
      end
    end

    assign ctrl_q[n] = c_r;
    assign time_q[n] = t_r;
  end

  // read mux: unmapped offsets fall through to zero
  always_comb begin
    rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit_ctrl[n]) rdata = ctrl_q[n];
      if (hit_time[n]) rdata = time_q[n];
    end
  end
endmodule

// File: rtl/pwm_lead_chan.sv
module pwm_lead_chan
  import pwm_lead_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl_word_t cfg,
  input  time_word_t tim,
  output logic       wave
);
  phase_t           ph, ph_n;
  logic [CNT_W-1:0] rem, rem_n;
  logic [CNT_W-1:0] off_act, off_act_n;
  logic [CNT_W-1:0] done_cnt, done_n;
  logic             start;
  logic             wrap;
  logic             last_period;

  // burst complete once the finishing period brings the count to the limit
  assign last_period = (cfg.burst != '0) &&
                       (({1'b0, done_cnt} + (CNT_W+1)'(1)) >= {1'b0, cfg.burst});

  always_comb begin
    ph_n      = ph;
    rem_n     = rem;
    off_act_n = off_act;
    done_n    = done_cnt;
    start     = 1'b0;
    wrap      = 1'b0;

    if (!cfg.run) begin
      ph_n   = PH_IDLE;
      rem_n  = '0;
      done_n = '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          done_n = '0;
          if (cfg.delay != '0) begin
            ph_n  = PH_DELAY;
            rem_n = CNT_W'(cfg.delay);
          end else begin
            start = 1'b1;
          end
        end
        PH_DELAY: begin
          if (rem > CNT_W'(1)) rem_n = rem - CNT_W'(1);
          else                 start = 1'b1;
        end
        PH_HIGH: begin
          if (rem > CNT_W'(1)) begin
            rem_n = rem - CNT_W'(1);
          end else if (off_act != '0) begin
            ph_n  = PH_LOW;
            rem_n = off_act;
          end else begin
            wrap = 1'b1;
          end
        end
        PH_LOW: begin
          if (rem > CNT_W'(1)) rem_n = rem - CNT_W'(1);
          else                 wrap  = 1'b1;
        end
        PH_DONE: ;
        default: ph_n = PH_IDLE;
      endcase

      if (wrap) begin
        if (last_period) begin
          ph_n  = PH_DONE;
          rem_n = '0;
        end else begin
          start = 1'b1;
          if (cfg.burst != '0) done_n = done_cnt + CNT_W'(1);
        end
      end

      // period start: sample the live timing word here and only here
      if (start) begin
        off_act_n = tim.off_t;
        if (tim.on_t != '0) begin
          ph_n  = PH_HIGH;
          rem_n = tim.on_t;
        end else begin
          ph_n  = PH_LOW;
          rem_n = (tim.off_t != '0) ? tim.off_t : CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      rem      <= '0;
      off_act  <= '0;
      done_cnt <= '0;
    end else begin
      ph       <= ph_n;
      rem      <= rem_n;
      off_act  <= off_act_n;
      done_cnt <= done_n;
    end
  end

  assign wave = (ph == PH_HIGH);
endmodule

// File: rtl/pwm_lead_array.sv
module pwm_lead_array
  import pwm_lead_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int ADDR_W   = 6,
  parameter int TIM_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  ctrl_word_t [NUM_CH-1:0] ctrl_q;
  time_word_t [NUM_CH-1:0] time_q;
  logic [NUM_CH-1:0]       chan_en;

  pwm_lead_regs #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .TIM_BASE (TIM_BASE)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .ctrl_q (ctrl_q),
    .time_q (time_q)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign chan_en[n] = ctrl_q[n].run;

    pwm_lead_chan chan_i (
      .clk  (clk),
      .rst  (rst),
      .cfg  (ctrl_q[n]),
      .tim  (time_q[n]),
      .wave (pwm_out[n])
    );
  end
endmodule

// File: rtl/pwm_lead_array_chk.sv
module pwm_lead_array_chk #(
  parameter int NUM_CH   = 6,
  parameter int ADDR_W   = 6,
  parameter int TIM_BASE = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] chan_en
);
  logic mapped;

  always_comb begin
    int a;
    a = int'(bus_addr);
    mapped = (a % 4 == 0) &&
             ((a < 4 * NUM_CH) || (a >= TIM_BASE && a < TIM_BASE + 4 * NUM_CH));
  end

  // R3: unmapped offsets read zero
  assert_unmapped_reads_zero_R3: assert property (
    @(posedge clk) disable iff (rst) !mapped |-> bus_rdata == 32'd0);

  // R1: first cycle after reset has every output low
  assert_outputs_low_after_reset_R1: assert property (
    @(posedge clk) $fell(rst) |-> pwm_out == '0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_prop
    // R7: cleared run bit forces the output low after the next edge
    assert_disable_stops_R7: assert property (
      @(posedge clk) disable iff (rst) !chan_en[n] |=> !pwm_out[n]);

    // R4: the edge that first sees the run bit still shows a low output
    assert_start_low_R4: assert property (
      @(posedge clk) disable iff (rst) $rose(chan_en[n]) |-> !pwm_out[n]);

    // R5: the output only rises on a channel that was running
    assert_rise_needs_run_R5: assert property (
      @(posedge clk) disable iff (rst) $rose(pwm_out[n]) |-> $past(chan_en[n]));
  end
endmodule

bind pwm_lead_array pwm_lead_array_chk #(
  .NUM_CH   (NUM_CH),
  .ADDR_W   (ADDR_W),
  .TIM_BASE (TIM_BASE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .chan_en   (chan_en)
);

// File: tb/pwm_lead_array_tb_top.sv
module pwm_lead_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic [5:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  pwm_out;

  int vec_cnt = 0;
  int err_cnt = 0;

  typedef struct {
    logic [NCH-1:0] mask;
    logic [NCH-1:0] val;
    string          tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  int p_delay[NCH];
  int p_on[NCH];
  int p_off[NCH];
  int p_burst[NCH];
  int p_skew[NCH];
  bit p_live[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_lead_array dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(int run, int dly, int bl);
    return {run[0], dly[14:0], bl[15:0]};
  endfunction

  function automatic logic [31:0] tw(int on_t, int off_t);
    return {on_t[15:0], off_t[15:0]};
  endfunction

  // expected level of channel c, j cycles after it first sees its run bit
  function automatic bit wave_at(int c, int j);
    int t, per;
    if (!p_live[c] || j < 0) return 1'b0;
    if (j < p_delay[c]) return 1'b0;
    t = j - p_delay[c];
    per = p_on[c] + p_off[c];
    if (per == 0) return 1'b0;
    if (p_burst[c] != 0 && (t / per) >= p_burst[c]) return 1'b0;
    return (t % per) < p_on[c];
  endfunction

  task automatic push_item(logic [NCH-1:0] v, string tag);
    exp_t e;
    e.mask = '1;
    e.val  = v;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // driver: item m is the output just after edge k+m, k = first write edge
  task automatic push_model(int n, string tag);
    for (int m = 0; m < n; m++) begin
      logic [NCH-1:0] v;
      for (int c = 0; c < NCH; c++) v[c] = wave_at(c, m - 1 - p_skew[c]);
      push_item(v, tag);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a[5:0];
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(int a, logic [31:0] e, string tag);
    bus_addr = a[5:0];
    #1;
    check(tag, bus_rdata, e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic all_off();
    for (int c = 0; c < NCH; c++) begin
      wr(4 * c, 32'd0);
      p_live[c] = 1'b0;
      p_skew[c] = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ch(int c, int dly, int on_t, int off_t, int bl, int skew);
    p_delay[c] = dly;
    p_on[c]    = on_t;
    p_off[c]   = off_t;
    p_burst[c] = bl;
    p_skew[c]  = skew;
    p_live[c]  = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  // monitor: pops one expected item per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        mon_e = exp_q.pop_front();
        check(mon_e.tag, 32'(pwm_out & mon_e.mask), 32'(mon_e.val));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      p_live[c] = 1'b0;
      p_skew[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 outputs after reset", 32'(pwm_out), 32'd0);
    for (int c = 0; c < NCH; c++) begin
      rd_check(4 * c, 32'd0, "R1 control cleared");
      rd_check(32 + 4 * c, 32'd0, "R1 timing cleared");
    end

    // R2: map and readback
    for (int c = 0; c < NCH; c++) begin
      wr(4 * c, cw(0, 16'h1230 + c, 16'h4500 + c));
      wr(32 + 4 * c, tw(16'h0100 + c, 16'h0200 + c));
    end
    for (int c = 0; c < NCH; c++) begin
      rd_check(4 * c, cw(0, 16'h1230 + c, 16'h4500 + c), "R2 control readback");
      rd_check(32 + 4 * c, tw(16'h0100 + c, 16'h0200 + c), "R2 timing readback");
    end

    // R3: unmapped and unaligned offsets
    for (int m = 0; m < 16; m++) push_item('0, "R3 outputs untouched");
    wr(24, 32'hFFFF_FFFF);
    wr(60, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(33, 32'hFFFF_FFFF);
    drain();
    rd_check(24, 32'd0, "R3 unmapped read 0x18");
    rd_check(60, 32'd0, "R3 unmapped read 0x3C");
    rd_check(1, 32'd0, "R3 unaligned read");
    for (int c = 0; c < NCH; c++) begin
      rd_check(4 * c, cw(0, 16'h1230 + c, 16'h4500 + c), "R3 control unchanged");
      rd_check(32 + 4 * c, tw(16'h0100 + c, 16'h0200 + c), "R3 timing unchanged");
    end
    all_off();

    // R4 and R5: start delay then endless on/off
    wr(32, tw(3, 2));
    set_ch(0, 4, 3, 2, 0, 0);
    push_model(32, "R4 R5 delay and waveform");
    wr(0, cw(1, 4, 0));
    drain();
    rd_check(0, cw(1, 4, 0), "R2 run bit readback");
    all_off();

    // R6: finite burst of two periods, then low while still running
    wr(32 + 12, tw(2, 3));
    set_ch(3, 1, 2, 3, 2, 0);
    push_model(24, "R6 burst of two");
    wr(12, cw(1, 1, 2));
    drain();
    all_off();

    // R7: disable in the middle of a long high phase
    wr(32 + 4, tw(20, 5));
    set_ch(1, 0, 20, 5, 0, 0);
    push_model(8, "R7 before disable");
    wr(4, cw(1, 0, 0));
    drain();
    push_item(6'b000010, "R7 edge that clears run");
    for (int m = 0; m < 5; m++) push_item('0, "R7 low after disable");
    p_live[1] = 1'b0;
    wr(4, 32'd0);
    drain();
    all_off();

    // R8: new timing written two cycles into a running period
    wr(32, tw(3, 2));
    push_item('0, "R8 latch edge");
    push_item(6'b1, "R8 old high");
    push_item(6'b1, "R8 old high");
    push_item(6'b1, "R8 old high");
    push_item('0, "R8 old low");
    push_item('0, "R8 old low");
    for (int p = 0; p < 2; p++) begin
      push_item(6'b1, "R8 new high");
      for (int m = 0; m < 4; m++) push_item('0, "R8 new low");
    end
    wr(0, cw(1, 0, 0));
    @(negedge clk);
    wr(32, tw(1, 4));
    drain();
    all_off();

    // R9 and R10: zero on-time, zero off-time, single burst, staggered starts
    wr(32 + 16, tw(0, 5));
    wr(32 + 20, tw(4, 0));
    wr(32 + 8, tw(3, 0));
    set_ch(4, 2, 0, 5, 0, 0);
    set_ch(5, 0, 4, 0, 0, 1);
    set_ch(2, 0, 3, 0, 2, 2);
    push_model(20, "R9 R10 zero phases");
    wr(16, cw(1, 2, 0));
    wr(20, cw(1, 0, 0));
    wr(8, cw(1, 0, 2));
    drain();
    all_off();

    // R10 and R6: independent channels, one endless and one with a burst of one
    wr(32, tw(2, 2));
    wr(32 + 20, tw(1, 3));
    set_ch(0, 0, 2, 2, 0, 0);
    set_ch(5, 3, 1, 3, 1, 1);
    push_model(24, "R10 R6 two channels");
    wr(0, cw(1, 0, 0));
    wr(20, cw(1, 3, 1));
    drain();

    // R1: reset while running clears everything
    for (int c = 0; c < NCH; c++) p_live[c] = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 outputs after second reset", 32'(pwm_out), 32'd0);
    rd_check(0, 32'd0, "R1 control cleared again");
    rd_check(52, 32'd0, "R1 timing cleared again");

    summary();
    $finish;
  end
endmodule